// File: doc/BRIEF.md
# Compressed Control-Transfer Resolver

This block resolves the five 16-bit compressed control-transfer forms: the unconditional jump, the register jump, the register jump with link, and the two compare-with-zero branches. An upstream decoder presents a valid strobe with the 16-bit instruction, its address and a 3-bit operation select. The block pulls the immediate fields out of the instruction itself. It drives a register-file read address combinationally and takes the read data back in the same cycle.

One clock later the block presents a registered result. The result holds the next program counter, an optional link write of the address plus 2 into x1, and an illegal flag. Register jumps that name x0 and operation selects outside the five forms are reported as illegal, and the program counter does not move.

Top module: `cxfer_resolve`

## Requirements
- R1: A cycle with `valid_i` high produces `res_valid_o` high on the next cycle, and `res_valid_o` is low after any cycle with `valid_i` low.
- R2: Operation select 0 (jump) gives `next_pc_o` = address + the sign-extended jump offset, where instruction bit 12 = off[11], 11 = off[4], 10:9 = off[9:8], 8 = off[10], 7 = off[6], 6 = off[7], 5:3 = off[3:1], 2 = off[5] and off[0] = 0. There is no link write.
- R3: Operation select 1 (register jump) reads register instruction[11:7] through `rf_raddr_o` and jumps to the value read. There is no link write.
- R4: Operation select 2 (register jump with link) jumps to the value read from instruction[11:7] and raises `link_we_o`, with `link_addr_o` = 1 and `link_data_o` = address + 2. When the source is x1, the target is the value of x1 before the link write.
- R5: For operation selects 1 and 2, a source field of 0 raises `illegal_o`, gives `next_pc_o` = address, and leaves `link_we_o` low.
- R6: Operation selects 3 and 4 (branch if zero, branch if nonzero) drive `rf_raddr_o` = 8 + instruction[9:7].
- R7: The branch-if-zero form is taken when the value read is zero, and the branch-if-nonzero form when it is nonzero. A taken branch gives address + branch offset. A branch that is not taken gives address + 2. Neither form writes a link.
- R8: The branch offset is sign-extended from bit 8, with instruction bits 12 = off[8], 11:10 = off[4:3], 6:5 = off[7:6], 4:3 = off[2:1], 2 = off[5], and off[0] = 0.
- R9: Operation selects 5, 6 and 7 raise `illegal_o` with `next_pc_o` = address and no link write.
- R10: After reset, `res_valid_o`, `next_pc_o`, `link_we_o`, `link_data_o` and `illegal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| instr_i | input | 16 | Compressed instruction |
| pc_i | input | XLEN | Address of the instruction |
| op_i | input | 3 | Operation select (0..4 supported) |
| rf_raddr_o | output | 5 | Register read address |
| rf_rdata_i | input | XLEN | Register read data, same cycle |
| res_valid_o | output | 1 | Result valid |
| next_pc_o | output | XLEN | Resolved next program counter |
| link_we_o | output | 1 | Link write enable |
| link_addr_o | output | 5 | Link register index (always 1) |
| link_data_o | output | XLEN | Link value |
| illegal_o | output | 1 | Request rejected |

## Verification
Every output field is registered once, so a wrong internal decision shows on the very next cycle after its request. A wrong offset bit position shows up as a `next_pc_o` that is off by a power of two. A wrong branch sense shows up as the taken and not-taken targets swapped. A wrong register alias shows up at once on `rf_raddr_o`, in the same cycle as the request. The bench model compares every field on every cycle, so no such error can stay hidden for longer than one cycle.

// File: rtl/cxfer_pkg.sv
package cxfer_pkg;
  typedef enum logic [2:0] {
    OP_JUMP    = 3'd0,
    OP_RJUMP   = 3'd1,
    OP_RJLINK  = 3'd2,
    OP_BR_ZERO = 3'd3,
    OP_BR_NZ   = 3'd4
  } cx_op_e;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned STEP_C   = 2;
  localparam int unsigned LINK_REG = 1;
endpackage

// File: rtl/cxfer_imm.sv
module cxfer_imm #(
  parameter int unsigned XLEN = 32
) (
  input  logic [12:2]     fld_i,
  output logic [XLEN-1:0] j_off_o,
  output logic [XLEN-1:0] b_off_o
);
  localparam int unsigned JW = 12;
  localparam int unsigned BW = 9;

  logic [JW-1:0] j_raw;
  logic [BW-1:0] b_raw;

  assign j_raw = {fld_i[12], fld_i[8], fld_i[10:9], fld_i[6], fld_i[7],
                  fld_i[2], fld_i[11], fld_i[5:3], 1'b0};
  assign b_raw = {fld_i[12], fld_i[6:5], fld_i[2], fld_i[11:10],
                  fld_i[4:3], 1'b0};

  assign j_off_o = {{(XLEN-JW){j_raw[JW-1]}}, j_raw};
  assign b_off_o = {{(XLEN-BW){b_raw[BW-1]}}, b_raw};

  always_comb begin
    assert_even_offsets_R8: assert (j_off_o[0] == 1'b0 && b_off_o[0] == 1'b0);
  end
endmodule

// File: rtl/cxfer_exec.sv
module cxfer_exec
  import cxfer_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [2:0]        op_i,
  input  logic [11:7]       rs_fld_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   j_off_i,
  input  logic [XLEN-1:0]   b_off_i,
  input  logic [XLEN-1:0]   rdata_i,
  output logic [REG_AW-1:0] raddr_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              link_we_o,
  output logic              illegal_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(STEP_C);

  cx_op_e op;
  logic   rs_zero;
  logic   val_zero;
  logic   taken;

  assign op       = cx_op_e'(op_i);
  assign rs_zero  = (rs_fld_i == '0);
  assign val_zero = (rdata_i == '0);

  always_comb begin
    raddr_o = '0;
    unique case (op)
      OP_RJUMP, OP_RJLINK:  raddr_o = rs_fld_i;
      OP_BR_ZERO, OP_BR_NZ: raddr_o = {2'b01, rs_fld_i[9:7]};
      default:              raddr_o = '0;
    endcase
  end

  always_comb begin
    next_pc_o = pc_i;
    link_we_o = 1'b0;
    illegal_o = 1'b0;
    taken     = 1'b0;
    case (op)
      OP_JUMP: next_pc_o = pc_i + j_off_i;
      OP_RJUMP, OP_RJLINK: begin
        if (rs_zero) begin
          illegal_o = 1'b1;
        end else begin
          next_pc_o = rdata_i;
          link_we_o = (op == OP_RJLINK);
        end
      end
      OP_BR_ZERO, OP_BR_NZ: begin
        taken     = (op == OP_BR_ZERO) ? val_zero : !val_zero;
        next_pc_o = taken ? pc_i + b_off_i : pc_i + STEP;
      end
      default: illegal_o = 1'b1;
    endcase
  end

  always_comb begin
    if (op == OP_BR_ZERO || op == OP_BR_NZ)
      assert_branch_alias_R6: assert (raddr_o[4:3] == 2'b01);
    if (illegal_o)
      assert_illegal_no_link_R5: assert (!link_we_o && next_pc_o == pc_i);
  end
endmodule

// File: rtl/cxfer_resolve.sv
module cxfer_resolve
  import cxfer_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [2:0]        op_i,
  output logic [4:0]        rf_raddr_o,
  input  logic [XLEN-1:0]   rf_rdata_i,
  output logic              res_valid_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              link_we_o,
  output logic [4:0]        link_addr_o,
  output logic [XLEN-1:0]   link_data_o,
  output logic              illegal_o
);
  logic [XLEN-1:0] j_off, b_off, nxt_d;
  logic            lwe_d, ill_d;

  cxfer_imm #(.XLEN(XLEN)) u_imm (
    .fld_i  (instr_i[12:2]),
    .j_off_o(j_off),
    .b_off_o(b_off)
  );

  cxfer_exec #(.XLEN(XLEN)) u_exec (
    .op_i     (op_i),
    .rs_fld_i (instr_i[11:7]),
    .pc_i     (pc_i),
    .j_off_i  (j_off),
    .b_off_i  (b_off),
    .rdata_i  (rf_rdata_i),
    .raddr_o  (rf_raddr_o),
    .next_pc_o(nxt_d),
    .link_we_o(lwe_d),
    .illegal_o(ill_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      next_pc_o   <= '0;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
      illegal_o   <= 1'b0;
    end else begin
      res_valid_o <= valid_i;
      if (valid_i) begin
        next_pc_o   <= nxt_d;
        link_we_o   <= lwe_d;
        link_data_o <= pc_i + XLEN'(STEP_C);
        illegal_o   <= ill_d;
      end else begin
        link_we_o   <= 1'b0;
      end
    end
  end

  assign link_addr_o = 5'(LINK_REG);

  assert_valid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> res_valid_o);
  assert_idle_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !res_valid_o);
  assert_jump_no_link_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_JUMP) |=> (!link_we_o && !illegal_o));
  assert_link_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_RJLINK && instr_i[11:7] != '0)
      |=> (link_we_o && link_data_o == $past(pc_i) + XLEN'(2)));
  assert_bad_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd4) |=> (illegal_o && next_pc_o == $past(pc_i)));
endmodule

// File: tb/cxfer_resolve_tb.sv
module cxfer_resolve_tb;
  localparam int XLEN = 32;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            valid;
  logic [15:0]     instr;
  logic [31:0]     pc;
  logic [2:0]      op;
  logic [4:0]      raddr;
  logic [31:0]     rdata;
  logic            res_valid, lwe, ill;
  logic [31:0]     npc, ldata;
  logic [4:0]      laddr;
  logic [31:0]     rf [32];

  int total = 0, bad = 0;

  bit          e_pend = 0;
  bit          e_valid;
  logic [31:0] e_pc, e_ldata;
  bit          e_lwe, e_ill;
  string       e_tag;

  always #10 clk = ~clk;

  assign rdata = rf[raddr];

  cxfer_resolve #(.XLEN(XLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr), .pc_i(pc),
    .op_i(op), .rf_raddr_o(raddr), .rf_rdata_i(rdata), .res_valid_o(res_valid),
    .next_pc_o(npc), .link_we_o(lwe), .link_addr_o(laddr), .link_data_o(ldata),
    .illegal_o(ill)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int jimm(logic [15:0] w);
    int v = 0;
    v += w[12] ? -2048 : 0;
    v += int'(w[8]) * 1024 + int'(w[10]) * 512 + int'(w[9]) * 256;
    v += int'(w[6]) * 128 + int'(w[7]) * 64 + int'(w[2]) * 32;
    v += int'(w[11]) * 16 + int'(w[5]) * 8 + int'(w[4]) * 4 + int'(w[3]) * 2;
    return v;
  endfunction

  function automatic int bimm(logic [15:0] w);
    int v = 0;
    v += w[12] ? -256 : 0;
    v += int'(w[6]) * 128 + int'(w[5]) * 64 + int'(w[2]) * 32;
    v += int'(w[11]) * 16 + int'(w[10]) * 8 + int'(w[4]) * 4 + int'(w[3]) * 2;
    return v;
  endfunction

  task automatic check_prev();
    if (!e_pend) return;
    chk({e_tag, " R1 valid"}, 32'(res_valid), 32'(e_valid));
    if (e_valid) begin
      chk({e_tag, " pc"}, npc, e_pc);
      chk({e_tag, " link_we"}, 32'(lwe), 32'(e_lwe));
      chk({e_tag, " illegal"}, 32'(ill), 32'(e_ill));
      if (e_lwe) begin
        chk("R4 link data", ldata, e_ldata);
        chk("R4 link addr", 32'(laddr), 32'd1);
      end
    end
  endtask

  task automatic step(bit v, logic [2:0] o, logic [15:0] w, logic [31:0] a);
    int idx;
    logic [31:0] val;
    @(negedge clk);
    check_prev();
    valid = v; op = o; instr = w; pc = a;
    #1;
    e_pend = 1; e_valid = v; e_lwe = 0; e_ill = 0; e_pc = a; e_ldata = a + 2;
    e_tag = "R1";
    if (!v) return;
    case (o)
      3'd0: begin e_tag = "R2 jump"; e_pc = a + 32'(jimm(w)); end
      3'd1, 3'd2: begin
        idx = int'(w[11:7]);
        if (idx == 0) begin
          e_tag = "R5 x0"; e_ill = 1;
        end else begin
          e_tag = (o == 3'd1) ? "R3 rjump" : "R4 rjlink";
          chk({e_tag, " raddr"}, 32'(raddr), 32'(idx));
          e_pc = rf[idx];
          e_lwe = (o == 3'd2);
        end
      end
      3'd3, 3'd4: begin
        idx = 8 + int'(w[9:7]);
        e_tag = "R7 branch";
        chk("R6 alias", 32'(raddr), 32'(idx));
        val = rf[idx];
        if ((o == 3'd3) == (val == 0)) begin
          e_tag = "R8 taken"; e_pc = a + 32'(bimm(w));
        end else e_pc = a + 2;
      end
      default: begin e_tag = "R9 bad op"; e_ill = 1; end
    endcase
  endtask

  initial begin
    #(20ns * 100000);
    total++; bad++;
    $display("FAIL watchdog");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0101_0104;
    rf[0] = 0; rf[9] = 0; rf[13] = 0;
    valid = 0; op = 0; instr = 0; pc = 0;
    repeat (3) @(negedge clk);
    chk("R10 valid", 32'(res_valid), 0);
    chk("R10 pc", npc, 0);
    chk("R10 link", 32'(lwe), 0);
    chk("R10 ldata", ldata, 0);
    chk("R10 illegal", 32'(ill), 0);
    rst_n = 1;
    // R2: all-ones field = -2, single bits
    step(1, 3'd0, 16'hFFFD, 32'h0000_8000);
    step(1, 3'd0, 16'h1000, 32'h0000_8000);
    for (int b = 2; b < 12; b++) step(1, 3'd0, 16'(1 << b) | 16'h0001, 32'h0000_4000);
    // R3 / R4 incl. x1 source
    step(1, 3'd1, 16'h8502, 32'h0000_1234);
    step(1, 3'd2, 16'h9082, 32'h0000_2000);
    step(1, 3'd2, 16'h9F82, 32'h0000_3000);
    step(0, 3'd0, 16'h0, 32'h0);
    // R5
    step(1, 3'd1, 16'h8002, 32'h0000_5550);
    step(1, 3'd2, 16'h9002, 32'h0000_5560);
    // R6 / R7 / R8: zero and nonzero registers, each offset bit
    for (int r = 0; r < 8; r++) begin
      step(1, 3'd3, 16'hC001 | 16'(r << 7) | 16'h0004, 32'h0000_6000);
      step(1, 3'd4, 16'hE001 | 16'(r << 7) | 16'h1000, 32'h0000_6000);
    end
    for (int b = 2; b < 13; b++) begin
      if (b >= 7 && b <= 9) continue;
      step(1, 3'd3, 16'hC081 | 16'(1 << b), 32'h0000_7000);
      step(1, 3'd4, 16'hE001 | 16'(1 << b), 32'h0000_7000);
    end
    // R9
    for (int o = 5; o < 8; o++) step(1, 3'(o), 16'h1234, 32'h0000_9000 + 32'(o));
    // mixed random traffic
    for (int k = 0; k < 200; k++)
      step(1'($urandom), 3'($urandom), 16'($urandom) & 16'hFFFC | 16'h0001,
           $urandom & 32'hFFFF_FFFE);
    step(0, 3'd0, 16'h0, 32'h0);
    step(0, 3'd0, 16'h0, 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule